// File: doc/BRIEF.md
# Cascadable Configuration Bitstream Reader

This block is the read side of a configuration memory. It streams a fixed image to an FPGA, either one byte per clock on an 8-bit bus or one bit per clock on the lowest data lane. An internal byte pointer moves forward on each qualifying rising edge of the configuration clock. A synchronous ROM holds the image, and its contents are generated from a seed parameter.

Several instances can be chained to form one long source. The cascade output of one memory feeds the chip-enable input of the next. Once a memory has delivered its last byte, it releases the data bus and pulls its cascade output low, and the next memory in the chain takes over on the following clock. Pulling the shared restart line low returns every memory in the chain to the start of its image. This is how a new configuration attempt always begins from the first byte.

Top module: `cfg_stream_rom`

## Requirements
- R1: While `rst_ni` is low, every memory sits at byte 0 of its image with `ceo_no` high. A memory with a nonzero image length starts with `data_oe_o` high if `ce_ni` is low.
- R2: The position advances only on a rising edge of `clk_i` where `ce_ni` is low, `oe_rst_ni` is high and the image is not exhausted. While `ce_ni` is high the position holds, and streaming resumes at the same place once `ce_ni` is low again.
- R3: With `par_mode_i` = 1, `data_o` carries the whole byte at the current address, and each qualifying edge moves to the next byte.
- R4: With `par_mode_i` = 0, `data_o[0]` carries one bit of the current byte and `data_o[7:1]` is 0. Bit 7 comes first and bit 0 last. A byte takes eight qualifying edges.
- R5: Image byte a equals ((37*a + SEED) XOR (a >> 2)) mod 256, where a counts from 0.
- R6: `data_oe_o` is high exactly when `ce_ni` is low and the image is not exhausted. While `data_oe_o` is low, `data_o` is 0 (released bus).
- R7: After IMAGE_BYTES bytes have been delivered, `ceo_no` is low while `ce_ni` is low. The memory then stays exhausted and further clocks do not move it.
- R8: While `ce_ni` is high, `ceo_no` is high and `data_oe_o` is low.
- R9: Driving `oe_rst_ni` low at any time restarts the image from byte 0 and drives `ceo_no` high. `par_mode_i` may change only while `oe_rst_ni` is low.
- R10: With IMAGE_BYTES = 0 the memory is exhausted from reset, so `ceo_no` follows `ce_ni` at once and `data_oe_o` never rises.
- R11: When `ceo_no` of one memory drives `ce_ni` of the next, the enabled outputs form one continuous stream: the second image's byte 0 (or bit 7 of byte 0) appears on the clock right after the first image's last unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| oe_rst_ni | input | 1 | Active-low restart; low returns to byte 0 |
| ce_ni | input | 1 | Active-low chip enable |
| par_mode_i | input | 1 | 1 = byte-wide output, 0 = bit-serial on lane 0 |
| data_o | output | 8 | Image data; 0 while released |
| data_oe_o | output | 1 | High while this memory drives the bus |
| ceo_no | output | 1 | Active-low cascade enable for the next memory |

## Verification
A wrong pointer becomes visible in the very next enabled cycle. In byte mode the bus shows a byte value that does not match the seeded formula. In serial mode the error shows within eight cycles as a bad bit on lane 0. A wrong exhaustion decision shows in the cycle where the image should end: the cascade output goes low early or late, and in a chain the next memory's first byte shifts by that many cycles. The bench runs three chained memories, one of them with an empty image, so a faulty handoff also shows on the downstream outputs.

// File: rtl/cfg_stream_pkg.sv
`timescale 1ns/1ps
package cfg_stream_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned BIT_IDX_W = $clog2(BYTE_W);

  typedef enum logic {
    MODE_SERIAL   = 1'b0,
    MODE_PARALLEL = 1'b1
  } cfg_mode_e;

  // seeded image content
  function automatic logic [BYTE_W-1:0] img_byte(input int unsigned addr,
                                                 input logic [BYTE_W-1:0] seed);
    logic [31:0] t;
    t = (addr * 32'd37) + {24'd0, seed};
    t = t ^ (addr >> 2);
    return t[BYTE_W-1:0];
  endfunction

endpackage

// File: rtl/cfg_rom.sv
`timescale 1ns/1ps
module cfg_rom
  import cfg_stream_pkg::*;
#(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned AW    = 1,
  parameter logic [BYTE_W-1:0] SEED = 8'h00
) (
  input  logic              clk_i,
  input  logic              arst_ni,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [BYTE_W-1:0] q_o
);

  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [BYTE_W-1:0] Q_RST = img_byte(0, SEED);

  logic [BYTE_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign mem[g] = img_byte(g, SEED);
  end

  logic [BYTE_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (rd_addr_i <= LAST_IDX) rd_word = mem[rd_addr_i];
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)     q_o <= Q_RST;
    else if (rd_en_i) q_o <= rd_word;
  end

endmodule

// File: rtl/cfg_addr_ctr.sv
`timescale 1ns/1ps
module cfg_addr_ctr
  import cfg_stream_pkg::*;
#(
  parameter int unsigned IMAGE_BYTES = 1,
  parameter int unsigned AW          = 1
) (
  input  logic                 clk_i,
  input  logic                 arst_ni,
  input  logic                 ce_ni,
  input  logic                 par_mode_i,
  output logic [AW-1:0]        addr_o,
  output logic [AW-1:0]        addr_nxt_o,
  output logic [BIT_IDX_W-1:0] bit_idx_o,
  output logic                 byte_step_o,
  output logic                 done_o
);

  localparam logic [AW-1:0]        LAST    = AW'(IMAGE_BYTES);
  localparam logic                 DONE_RST = (IMAGE_BYTES == 0);
  localparam logic [BIT_IDX_W-1:0] BIT_MAX = '1;

  logic [AW-1:0]        addr_q;
  logic [BIT_IDX_W-1:0] bit_q;
  logic                 done_q;
  logic                 step;

  assign step        = !ce_ni && !done_q;
  assign byte_step_o = step && (par_mode_i || (bit_q == BIT_MAX));
  assign addr_nxt_o  = addr_q + 1'b1;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      addr_q <= '0;
      bit_q  <= '0;
      done_q <= DONE_RST;
    end else begin
      if (step && !par_mode_i) bit_q <= bit_q + 1'b1;
      if (byte_step_o) begin
        addr_q <= addr_nxt_o;
        done_q <= (addr_nxt_o == LAST);
      end
    end
  end

  assign addr_o    = addr_q;
  assign bit_idx_o = bit_q;
  assign done_o    = done_q;

endmodule

// File: rtl/cfg_out_stage.sv
`timescale 1ns/1ps
module cfg_out_stage
  import cfg_stream_pkg::*;
(
  input  logic                 ce_ni,
  input  logic                 done_i,
  input  logic                 par_mode_i,
  input  logic [BYTE_W-1:0]    word_i,
  input  logic [BIT_IDX_W-1:0] bit_idx_i,
  output logic [BYTE_W-1:0]    data_o,
  output logic                 data_oe_o,
  output logic                 ceo_no
);

  logic                 drive;
  logic                 ser_bit;
  logic [BIT_IDX_W-1:0] sel;

  assign drive     = !ce_ni && !done_i;
  assign ceo_no    = !(!ce_ni && done_i);
  assign data_oe_o = drive;
  assign sel       = BIT_IDX_W'(BYTE_W - 1) - bit_idx_i;  // msb first
  assign ser_bit   = word_i[sel];

  for (genvar g = 0; g < BYTE_W; g++) begin : g_lane
    if (g == 0) begin : g_ser
      assign data_o[g] = drive && (par_mode_i ? word_i[g] : ser_bit);
    end else begin : g_par
      assign data_o[g] = drive && par_mode_i && word_i[g];
    end
  end

endmodule

// File: rtl/cfg_stream_rom.sv
`timescale 1ns/1ps
module cfg_stream_rom
  import cfg_stream_pkg::*;
#(
  parameter int unsigned IMAGE_BYTES = 24,
  parameter logic [7:0]  SEED        = 8'h5A
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       oe_rst_ni,
  input  logic       ce_ni,
  input  logic       par_mode_i,
  output logic [7:0] data_o,
  output logic       data_oe_o,
  output logic       ceo_no
);

  localparam int unsigned AW    = $clog2(IMAGE_BYTES + 2);
  localparam int unsigned DEPTH = IMAGE_BYTES + 1;

  logic                 arst_n;
  logic [AW-1:0]        addr_w;
  logic [AW-1:0]        addr_nxt_w;
  logic [BIT_IDX_W-1:0] bit_idx_w;
  logic                 byte_step_w;
  logic                 done_w;
  logic [BYTE_W-1:0]    word_w;

  // restart shares the async clear with power-on reset
  assign arst_n = rst_ni & oe_rst_ni;

  cfg_addr_ctr #(
    .IMAGE_BYTES(IMAGE_BYTES),
    .AW         (AW)
  ) u_ctr (
    .clk_i      (clk_i),
    .arst_ni    (arst_n),
    .ce_ni      (ce_ni),
    .par_mode_i (par_mode_i),
    .addr_o     (addr_w),
    .addr_nxt_o (addr_nxt_w),
    .bit_idx_o  (bit_idx_w),
    .byte_step_o(byte_step_w),
    .done_o     (done_w)
  );

  cfg_rom #(
    .DEPTH(DEPTH),
    .AW   (AW),
    .SEED (SEED)
  ) u_rom (
    .clk_i    (clk_i),
    .arst_ni  (arst_n),
    .rd_en_i  (byte_step_w),
    .rd_addr_i(addr_nxt_w),
    .q_o      (word_w)
  );

  cfg_out_stage u_out (
    .ce_ni     (ce_ni),
    .done_i    (done_w),
    .par_mode_i(par_mode_i),
    .word_i    (word_w),
    .bit_idx_i (bit_idx_w),
    .data_o    (data_o),
    .data_oe_o (data_oe_o),
    .ceo_no    (ceo_no)
  );

endmodule

// File: rtl/cfg_stream_chk.sv
`timescale 1ns/1ps
module cfg_stream_chk #(
  parameter int unsigned IMAGE_BYTES = 1,
  parameter int unsigned AW          = 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          oe_rst_ni,
  input logic          ce_ni,
  input logic          par_mode_i,
  input logic [7:0]    data_o,
  input logic          data_oe_o,
  input logic          ceo_no,
  input logic [AW-1:0] addr_i
);

  localparam logic [AW-1:0] LAST = AW'(IMAGE_BYTES);

  assert_ce_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> (ceo_no && !data_oe_o));

  assert_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_rst_ni |-> ceo_no);

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || !oe_rst_ni)
    ce_ni |=> $stable(addr_i));

  assert_par_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !oe_rst_ni)
    (par_mode_i && !ce_ni && data_oe_o) |=> (addr_i == AW'($past(addr_i) + 1'b1)));

  assert_end_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni || !oe_rst_ni)
    !ceo_no |=> $stable(addr_i));

  assert_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i <= LAST);

  assert_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == 8'h00));

  assert_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(data_oe_o && !ceo_no));

  assert_ser_lanes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_mode_i |-> (data_o[7:1] == 7'd0));

endmodule

bind cfg_stream_rom cfg_stream_chk #(
  .IMAGE_BYTES(IMAGE_BYTES),
  .AW         (AW)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .oe_rst_ni (oe_rst_ni),
  .ce_ni     (ce_ni),
  .par_mode_i(par_mode_i),
  .data_o    (data_o),
  .data_oe_o (data_oe_o),
  .ceo_no    (ceo_no),
  .addr_i    (addr_w)
);

// File: tb/cfg_stream_rom_bench.sv
`timescale 1ns/1ps
module cfg_stream_rom_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NDEV = 3;
  localparam int LEN0 = 24;
  localparam int LEN1 = 0;
  localparam int LEN2 = 6;
  localparam logic [7:0] SEED0 = 8'h5A;
  localparam logic [7:0] SEED1 = 8'h11;
  localparam logic [7:0] SEED2 = 8'hC3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oe_rst_n = 1'b1;
  logic ce_n = 1'b1;
  logic par = 1'b1;

  logic [7:0] d0, d1, d2;
  logic oe0, oe1, oe2;
  logic ceo0, ceo1, ceo2;

  always #(CLK_PERIOD/2) clk = ~clk;

  // three memories in a chain; the middle one holds an empty image
  cfg_stream_rom u_cfg_stream_rom (
    .clk_i(clk), .rst_ni(rst_n), .oe_rst_ni(oe_rst_n), .ce_ni(ce_n),
    .par_mode_i(par), .data_o(d0), .data_oe_o(oe0), .ceo_no(ceo0));

  cfg_stream_rom #(.IMAGE_BYTES(LEN1), .SEED(SEED1)) u_cfg_stream_rom_mid (
    .clk_i(clk), .rst_ni(rst_n), .oe_rst_ni(oe_rst_n), .ce_ni(ceo0),
    .par_mode_i(par), .data_o(d1), .data_oe_o(oe1), .ceo_no(ceo1));

  cfg_stream_rom #(.IMAGE_BYTES(LEN2), .SEED(SEED2)) u_cfg_stream_rom_tail (
    .clk_i(clk), .rst_ni(rst_n), .oe_rst_ni(oe_rst_n), .ce_ni(ceo1),
    .par_mode_i(par), .data_o(d2), .data_oe_o(oe2), .ceo_no(ceo2));

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int pos [NDEV];

  function automatic int dev_len(int d);
    return (d == 0) ? LEN0 : (d == 1) ? LEN1 : LEN2;
  endfunction

  function automatic logic [7:0] dev_seed(int d);
    return (d == 0) ? SEED0 : (d == 1) ? SEED1 : SEED2;
  endfunction

  // R5 image formula
  function automatic logic [7:0] exp_byte(int a, logic [7:0] seed);
    int t;
    t = ((a * 37) + int'(seed)) ^ (a >> 2);
    return 8'(t & 255);
  endfunction

  function automatic int total_units(int d);
    return par ? dev_len(d) : 8 * dev_len(d);
  endfunction

  function automatic bit exhausted(int d);
    return pos[d] >= total_units(d);
  endfunction

  function automatic logic [7:0] exp_data(int d, bit en);
    logic [7:0] b;
    if (!en) return 8'h00;
    if (par) return exp_byte(pos[d], dev_seed(d));
    b = exp_byte(pos[d] >> 3, dev_seed(d));
    return {7'd0, b[7 - (pos[d] & 7)]};
  endfunction

  task automatic cmp(string tag, string what, int d, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s dev%0d %s actual=%h expected=%h pos=%0d", tag, d, what, act, exp, pos[d]);
    end
  endtask

  task automatic check_all(string tag);
    bit ce_m;
    bit en, ceo_m;
    logic [7:0] ad;
    logic       aoe, aceo;
    ce_m = ce_n;
    for (int d = 0; d < NDEV; d++) begin
      en    = !ce_m && !exhausted(d);
      ceo_m = !(!ce_m && exhausted(d));
      ad   = (d == 0) ? d0 : (d == 1) ? d1 : d2;
      aoe  = (d == 0) ? oe0 : (d == 1) ? oe1 : oe2;
      aceo = (d == 0) ? ceo0 : (d == 1) ? ceo1 : ceo2;
      cmp(tag, "ceo_no", d, {7'd0, aceo}, {7'd0, ceo_m});
      cmp(tag, "data_oe_o", d, {7'd0, aoe}, {7'd0, en});
      cmp(tag, "data_o", d, ad, exp_data(d, en));
      ce_m = ceo_m;
    end
  endtask

  task automatic advance_model();
    bit ce_m;
    bit was_done;
    if (!rst_n || !oe_rst_n) begin
      for (int d = 0; d < NDEV; d++) pos[d] = 0;
      return;
    end
    ce_m = ce_n;
    for (int d = 0; d < NDEV; d++) begin
      was_done = exhausted(d);
      if (!ce_m && !was_done) pos[d]++;
      ce_m = !(!ce_m && was_done);
    end
  endtask

  task automatic step(bit ce, bit orst, string tag);
    @(negedge clk);
    ce_n = ce;
    oe_rst_n = orst;
    if (!orst) for (int d = 0; d < NDEV; d++) pos[d] = 0;
    #1;
    check_all(tag);
    @(posedge clk);
    advance_model();
  endtask

  task automatic restart(bit mode, string tag);
    @(negedge clk);
    oe_rst_n = 1'b0;
    ce_n = 1'b0;
    for (int d = 0; d < NDEV; d++) pos[d] = 0;
    #1;
    par = mode;
    #1;
    check_all(tag);
    @(posedge clk);
    advance_model();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int d = 0; d < NDEV; d++) pos[d] = 0;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;

    // byte mode through the whole chain: R3 R5 R10 R11, then exhausted R7
    restart(1'b1, "R9 restart par");
    step(1'b0, 1'b1, "R1 first byte");
    for (int i = 0; i < LEN0 + LEN2 + 4; i++) step(1'b0, 1'b1, "R3 R11 par stream");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R7 exhausted");
    step(1'b1, 1'b1, "R8 ce off after end");
    step(1'b0, 1'b1, "R7 still exhausted");

    // pause in mid image, then resume: R2 R8
    restart(1'b1, "R9 restart");
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, "R3 par");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "R2 R8 paused");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, "R2 resume");
    // restart mid stream: R9
    step(1'b0, 1'b0, "R9 restart low");
    step(1'b0, 1'b1, "R9 back at byte 0");

    // serial mode, full chain, msb first: R4 R11
    restart(1'b0, "R9 restart ser");
    for (int i = 0; i < 8 * (LEN0 + LEN2) + 6; i++) step(1'b0, 1'b1, "R4 R11 serial");
    step(1'b1, 1'b1, "R8 R10 ser idle");

    // random mix: R2 R3 R4 R6 R9
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 2) restart(1'($urandom_range(0, 1)), "R9 rnd restart");
      else step(r >= 80, 1'b1, "R6 rnd");
    end

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule